// File: doc/BRIEF.md
# Configurable UART transmitter

This block serialises bytes onto one idle-high line. A single 32-bit configuration word sets the whole frame format at run time: how many clock cycles one bit lasts, how many data bits a frame carries (five to eight), whether one or two stop bits close it, and which parity bit, if any, goes after the data. Bytes arrive over a valid/ready handshake. The block takes a byte only when it is idle, and holds `busy` high until the last stop bit has been sent.

The configuration word is sampled in the cycle a byte is accepted and stays frozen for that frame. Software or a wrapper may therefore rewrite the word at any moment, and the change reaches the line only with the next frame. The controller is a five-state machine. `ST_IDLE` goes to `ST_START` when a byte is accepted. `ST_START` goes to `ST_DATA` after one bit time. `ST_DATA` goes to `ST_PARITY` after the last data bit when parity is enabled, and to `ST_STOP` otherwise. `ST_PARITY` goes to `ST_STOP` after one bit time. `ST_STOP` returns to `ST_IDLE` after one or two bit times. Every move except the one out of `ST_IDLE` happens on a tick of the bit-time counter.

Configuration word layout: bits [23:0] hold the clocks per bit, [25:24] hold the data length minus five, [26] selects two stop bits, [27] enables parity, [28] selects fixed parity, and [29] selects odd parity (or mark when fixed). Bits [31:30] are unused.

Top module: `cfg_uart_tx`

## Requirements
- R1: Out of reset and whenever no frame is in flight, `tx_line` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. From that edge until the last stop bit ends, `in_ready` is 0 and `busy` is 1.
- R3: A frame starts with one start bit at 0, followed by the data bits least significant first. The number of data bits is cfg[25:24] + 5, and byte bits above that width are never sent.
- R4: Each bit lasts exactly cfg[23:0] clock cycles. A value of 0 is treated as 1.
- R5: When cfg[27] is 1, a parity bit follows the data. With cfg[28]=0 it is odd parity when cfg[29]=1, so the data bits plus parity hold an odd count of ones, and even parity when cfg[29]=0. With cfg[28]=1 the bit is fixed at the value of cfg[29] (1 = mark, 0 = space). When cfg[27] is 0, no parity bit is sent.
- R6: The frame ends with stop bits at 1: two when cfg[26] is 1, one otherwise.
- R7: The configuration word is sampled only on the accepting edge. Changing it during a frame has no effect on that frame.
- R8: After the last stop bit the block spends at least one cycle idle, with the line at 1 and `in_ready` at 1. A byte held valid across the frame is accepted on the edge that ends that idle cycle.
- R9: Changing `in_data` or holding `in_valid` high while a frame is in flight does not change the bits being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Frame format and bit time, sampled on acceptance |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | High only when idle; the byte is taken on valid and ready |
| busy | output | 1 | A frame is in flight |
| tx_line | output | 1 | Serial output, idle high |

## Verification
The assertions assume that `in_valid` and `in_data` change only away from the rising edge, and that `cfg_word` may change at any time, since the frozen copy is what is checked for stability. They also assume the bit time stays small enough that the line changes only on the counter's tick. The bench drives every input on the falling edge. It uses bit times of 0 to 5 cycles, so each frame can be followed cycle by cycle and the sampled value is compared in every cycle of every bit. It also rewrites the configuration and the data in the first cycle of a frame, to confirm that neither reaches the line until the next acceptance.

// File: rtl/cfg_uart_tx_pkg.sv
package cfg_uart_tx_pkg;

    localparam int CFG_W     = 32;
    localparam int DIV_W     = 24;
    localparam int DATA_W    = 8;
    localparam int LEN_W     = 2;
    localparam int CNT_W     = $clog2(DATA_W);
    localparam int MIN_BITS  = 5;

    localparam int LEN_LSB   = DIV_W;
    localparam int STOP2_BIT = LEN_LSB + LEN_W;
    localparam int PEN_BIT   = STOP2_BIT + 1;
    localparam int PFIX_BIT  = PEN_BIT + 1;
    localparam int PSEL_BIT  = PFIX_BIT + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] clk_per_bit;
        logic [LEN_W-1:0] len_m5;
        logic             two_stop;
        logic             par_en;
        logic             par_fixed;
        logic             par_sel;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        frame_cfg_t c;
        c.clk_per_bit = w[DIV_W-1:0];
        c.len_m5      = w[LEN_LSB +: LEN_W];
        c.two_stop    = w[STOP2_BIT];
        c.par_en      = w[PEN_BIT];
        c.par_fixed   = w[PFIX_BIT];
        c.par_sel     = w[PSEL_BIT];
        return c;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
    import cfg_uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;

    // A divisor of zero behaves as one: every cycle is a tick.
    assign reload = (divisor == '0) ? '0 : divisor - DIV_W'(1);
    assign tick   = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import cfg_uart_tx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len_m5,
    input  logic              par_fixed,
    input  logic              par_sel,
    output logic              par_bit
);
    logic [DATA_W-1:0] mask;
    logic              xor_all;

    // Only the configured data bits take part in the parity.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (4'(g) < (4'(len_m5) + 4'(MIN_BITS)));
    end

    assign xor_all = ^(data & mask);

    always_comb begin
        if (par_fixed) begin
            par_bit = par_sel;
        end else if (par_sel) begin
            par_bit = ~xor_all;
        end else begin
            par_bit = xor_all;
        end
    end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import cfg_uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              tick,
    input  logic              par_bit,
    output logic              accept,
    output frame_cfg_t        cfg_q,
    output logic [DATA_W-1:0] data_q,
    output logic              in_ready,
    output logic              busy,
    output logic              tx_line
);
    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              last_data;
    logic              last_stop;

    assign accept    = in_valid && (state_q == ST_IDLE);
    assign last_data = (bit_cnt_q == (CNT_W'(cfg_q.len_m5) + CNT_W'(MIN_BITS - 1)));
    assign last_stop = (bit_cnt_q == CNT_W'(cfg_q.two_stop));

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_START;
            ST_START:  if (tick) state_d = ST_DATA;
            ST_DATA:   if (tick && last_data) state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick) state_d = ST_STOP;
            ST_STOP:   if (tick && last_stop) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            data_q    <= '0;
            cfg_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                shreg_q <= in_data;
                data_q  <= in_data;
                cfg_q   <= decode_cfg(cfg_word);
            end else if (state_q == ST_DATA && tick) begin
                shreg_q <= shreg_q >> 1;
            end
            if (state_d != state_q) begin
                bit_cnt_q <= '0;
            end else if (tick && state_q != ST_IDLE) begin
                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        in_ready = 1'b0;
        busy     = 1'b1;
        tx_line  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                busy     = 1'b0;
            end
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg_q[0];
            ST_PARITY: tx_line = par_bit;
            ST_STOP:   tx_line = 1'b1;
            default:   tx_line = 1'b1;
        endcase
    end
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
    import cfg_uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              tx_line
);
    logic              accept;
    logic              baud_tick;
    logic              par_bit;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] data_q;
    logic [DIV_W-1:0]  div_sel;

    // On the accepting edge the counter loads from the incoming word.
    assign div_sel = accept ? cfg_word[DIV_W-1:0] : cfg_q.clk_per_bit;

    uart_tx_baud u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .divisor (div_sel),
        .tick    (baud_tick)
    );

    uart_tx_parity u_par (
        .data      (data_q),
        .len_m5    (cfg_q.len_m5),
        .par_fixed (cfg_q.par_fixed),
        .par_sel   (cfg_q.par_sel),
        .par_bit   (par_bit)
    );

    uart_tx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_word (cfg_word),
        .in_valid (in_valid),
        .in_data  (in_data),
        .tick     (baud_tick),
        .par_bit  (par_bit),
        .accept   (accept),
        .cfg_q    (cfg_q),
        .data_q   (data_q),
        .in_ready (in_ready),
        .busy     (busy),
        .tx_line  (tx_line)
    );
endmodule

// File: rtl/cfg_uart_tx_chk.sv
module cfg_uart_tx_chk
    import cfg_uart_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       busy,
    input logic       tx_line,
    input logic       tick,
    input frame_cfg_t cfg_q
);
    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready != busy);

    p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !tx_line));

    p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(tx_line));

    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_q));

    p_stop_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_line));
endmodule

bind cfg_uart_tx cfg_uart_tx_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .tx_line  (tx_line),
    .tick     (baud_tick),
    .cfg_q    (cfg_q)
);

// File: tb/cfg_uart_tx_tb_top.sv
module cfg_uart_tx_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        busy;
    logic        tx_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_uart_tx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_word (cfg_word),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .busy     (busy),
        .tx_line  (tx_line)
    );

    function automatic logic [31:0] mk(input int cpb, input int nbits, input bit two,
                                       input bit pen, input bit pfix, input bit psel);
        logic [31:0] w;
        w        = '0;
        w[23:0]  = 24'(cpb);
        w[25:24] = 2'(nbits - 5);
        w[26]    = two;
        w[27]    = pen;
        w[28]    = pfix;
        w[29]    = psel;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Accept a byte: drive at the falling edge, confirm ready, return after the accepting edge.
    task automatic offer(input logic [31:0] cfg, input logic [7:0] d);
        @(negedge clk);
        cfg_word = cfg;
        in_data  = d;
        in_valid = 1'b1;
        chk(in_ready === 1'b1, "R2 ready before offer", 32'(in_ready), 1);
        @(posedge clk);
    endtask

    // Follow one frame from the accepting edge; expected bits built from the requirements.
    task automatic watch(input logic [31:0] cfg, input logic [7:0] d, input string tag,
                         input bit keep_valid, input logic [7:0] next_d,
                         input bit swap_cfg, input logic [31:0] new_cfg);
        int          cpb;
        int          nb;
        int          n;
        int          ones;
        logic [11:0] bits;
        cpb  = (cfg[23:0] == 0) ? 1 : int'(cfg[23:0]);
        nb   = int'(cfg[25:24]) + 5;
        bits = '1;
        n    = 0;
        bits[n++] = 1'b0;
        ones = 0;
        for (int i = 0; i < nb; i++) begin
            bits[n++] = d[i];
            ones += int'(d[i]);
        end
        if (cfg[27]) begin
            if (cfg[28]) bits[n++] = cfg[29];
            else if (cfg[29]) bits[n++] = ((ones % 2) == 0);
            else bits[n++] = ((ones % 2) == 1);
        end
        bits[n++] = 1'b1;
        if (cfg[26]) bits[n++] = 1'b1;
        for (int b = 0; b < n; b++) begin
            int   bad = 0;
            logic act = 1'b0;
            for (int c = 0; c < cpb; c++) begin
                @(negedge clk);
                if (b == 0 && c == 0) begin
                    if (keep_valid) in_data = next_d;
                    else in_valid = 1'b0;
                    if (swap_cfg) cfg_word = new_cfg;
                end
                if (tx_line !== bits[b] || busy !== 1'b1 || in_ready !== 1'b0) begin
                    if (bad == 0) act = tx_line;
                    bad++;
                end
            end
            chk(bad == 0, $sformatf("%s bit %0d", tag, b), 32'(act), 32'(bits[b]));
        end
        @(negedge clk);
        chk(tx_line === 1'b1 && in_ready === 1'b1 && busy === 1'b0,
            $sformatf("R8 %s idle after frame", tag), {in_ready, busy, tx_line}, 3'b101);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line === 1'b1 && in_ready === 1'b1 && busy === 1'b0, "R1 reset state",
            {in_ready, busy, tx_line}, 3'b101);
    endtask

    task automatic t_plain();
        logic [31:0] c = mk(4, 8, 0, 0, 0, 0);
        offer(c, 8'hA5);
        watch(c, 8'hA5, "R3 R4 R6 8N1", 0, 0, 0, 0);
    endtask

    task automatic t_even_short();
        logic [31:0] c = mk(3, 7, 0, 1, 0, 0);
        offer(c, 8'hB5);
        watch(c, 8'hB5, "R3 R5 7E1 high bit dropped", 0, 0, 0, 0);
    endtask

    task automatic t_odd_two_stop();
        logic [31:0] c = mk(2, 5, 1, 1, 0, 1);
        offer(c, 8'h1F);
        watch(c, 8'h1F, "R5 R6 5O2", 0, 0, 0, 0);
        c = mk(5, 8, 0, 1, 0, 1);
        offer(c, 8'h03);
        watch(c, 8'h03, "R5 8O1 even count", 0, 0, 0, 0);
    endtask

    task automatic t_fixed_parity();
        logic [31:0] c = mk(1, 6, 0, 1, 1, 1);
        offer(c, 8'h00);
        watch(c, 8'h00, "R5 R4 6M1 one clock", 0, 0, 0, 0);
        c = mk(0, 8, 1, 1, 1, 0);
        offer(c, 8'hFF);
        watch(c, 8'hFF, "R4 R5 8S2 zero divisor", 0, 0, 0, 0);
    endtask

    task automatic t_midframe();
        logic [31:0] a = mk(3, 8, 0, 0, 0, 0);
        logic [31:0] b = mk(5, 5, 1, 1, 0, 0);
        offer(a, 8'h6C);
        watch(a, 8'h6C, "R7 R9 frozen frame", 1, 8'h93, 1, b);
        @(posedge clk);
        watch(b, 8'h93, "R7 R8 held byte new cfg", 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_even_short();
        t_odd_two_stop();
        t_fixed_parity();
        t_midframe();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule